// File: doc/BRIEF.md
# Tri-State Symbol Pulse Transmitter

This block repeatedly sends a fixed code word on one serial line, in the style of a simple remote-control transmitter. The word holds a set of address symbols, each with three possible values (zero, one, floating), followed by an optional group of binary data bits. Each symbol is sent as two pulses. A pulse is either short or long, and every pulse has the same period. A zero is two long pulses. A one is two short pulses. A floating symbol is one long pulse and then one short pulse. Data bits use the same pulse shapes but only take the values zero and one.

Every input symbol arrives as a 2-bit code. Sensing a floating pin is left to logic outside the block. The block takes a snapshot of all codes at the start of each word. It then sends the address symbols from index 0 upward, followed by the data bits from index 0 upward. After the last pulse it holds the line low for a sync gap and then starts again. This continues for as long as the enable input stays high. Parameters set the symbol counts and the number of clock ticks in one time unit, so any of the usual layouts can be built: 12 symbols with no data, 10 symbols with 8 data bits, or 8 symbols with 4 data bits.

Top module: `tpe_top`

## Requirements
- R1: An address code 2'b00 (zero) is sent as two long pulses. A long pulse is high for 3 units and then low for 1 unit.
- R2: An address code 2'b01 (one) is sent as two short pulses. A short pulse is high for 1 unit and then low for 3 units.
- R3: An address code 2'b10 or 2'b11 (floating) is sent as a long pulse followed by a short pulse.
- R4: A data code 2'b00 is sent as two long pulses. Any other data code, including a floating code, is sent as two short pulses.
- R5: Symbol k sits in bits [2k+1:2k] of its input vector. A word sends the address symbols from index 0 to the highest index, then the data bits from index 0 to the highest index, with no spacing between pulses.
- R6: One unit is UNIT_TICKS clock cycles, and every pulse lasts 4 units. When the block is idle, the output goes high in the cycle after the first rising clock edge at which enable is seen high.
- R7: After the last pulse of a word, the output stays low for GAP_UNITS units. While enable stays high, the next word then starts with no further action.
- R8: The input codes are captured only when a word starts. A change to the inputs during a word has no effect until the next word.
- R9: While reset is high, or from the cycle after enable is seen low, the output is low. A later enable starts a new word from symbol 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmit enable; while high, words repeat |
| addrSym | input | 2*ADDR_SYMS | Address symbol codes, 2 bits per symbol |
| dataSym | input | 2*max(DATA_BITS,1) | Data bit codes, 2 bits per bit |
| txOut | output | 1 | Serial pulse output |

## Verification
The bench checks every pulse of each word, one clock cycle at a time. This catches a design that swaps the order of the two pulses in a floating symbol, treats code 2'b11 as a zero, or sends a floating data code as zero. It changes the inputs in the middle of a word. A design that does not take a snapshot would let the new codes leak into the later pulses of that word. It also checks that the sync gap has the exact length and that the next word starts right after it. A design with an off-by-one error in its gap counter would shift the whole next word. Finally, it drops enable part-way through a word and then raises it again. A design that kept its position in the word would restart in the middle instead of at symbol 0.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int PULSE_UNITS = 4;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_ONE  = 2'b01;

  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_GAP} phase_t;

  typedef struct packed {
    logic load;    // capture input codes this edge
    logic shift;   // advance to next symbol this edge
    logic active;  // a pulse is being sent
    logic second;  // second pulse of the symbol
    logic early;   // first unit of a pulse
    logic late;    // last unit of a pulse
  } strobe_t;
endpackage

// File: rtl/tpe_ctrl.sv
module tpe_ctrl #(
  parameter int TOTAL_SYMS = 18,
  parameter int UNIT_TICKS = 2,
  parameter int GAP_UNITS  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output tpe_pkg::strobe_t strobes
);
  import tpe_pkg::*;

  localparam int TW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int UW = (GAP_UNITS > PULSE_UNITS) ? $clog2(GAP_UNITS) : 2;
  localparam int SW = (TOTAL_SYMS > 1) ? $clog2(TOTAL_SYMS) : 1;
  localparam logic [TW-1:0] TICK_LAST  = TW'(UNIT_TICKS - 1);
  localparam logic [UW-1:0] PULSE_LAST = UW'(PULSE_UNITS - 1);
  localparam logic [UW-1:0] GAP_LAST   = UW'(GAP_UNITS - 1);
  localparam logic [SW-1:0] SYM_LAST   = SW'(TOTAL_SYMS - 1);

  phase_t        phase;
  logic [TW-1:0] tickCnt;
  logic [UW-1:0] unitCnt;
  logic [SW-1:0] symCnt;
  logic          second;
  logic          lastTick, pulseEnd, gapEnd;

  always_comb begin
    lastTick = (tickCnt == TICK_LAST);
    pulseEnd = (phase == PH_SEND) && lastTick && (unitCnt == PULSE_LAST);
    gapEnd   = (phase == PH_GAP) && lastTick && (unitCnt == GAP_LAST);
    strobes.load   = en && ((phase == PH_IDLE) || gapEnd);
    strobes.shift  = pulseEnd && second;
    strobes.active = (phase == PH_SEND);
    strobes.second = second;
    strobes.early  = (unitCnt == '0);
    strobes.late   = (unitCnt == PULSE_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      unitCnt <= '0;
      symCnt  <= '0;
      second  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase   <= PH_SEND;
          tickCnt <= '0;
          unitCnt <= '0;
          symCnt  <= '0;
          second  <= 1'b0;
        end
        PH_SEND: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (unitCnt == PULSE_LAST) begin
              unitCnt <= '0;
              second  <= ~second;
              if (second) begin
                if (symCnt == SYM_LAST) begin
                  symCnt <= '0;
                  phase  <= PH_GAP;
                end else begin
                  symCnt <= symCnt + 1'b1;
                end
              end
            end else begin
              unitCnt <= unitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        PH_GAP: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (unitCnt == GAP_LAST) begin
              unitCnt <= '0;
              phase   <= PH_SEND;
            end else begin
              unitCnt <= unitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpe_datapath.sv
module tpe_datapath #(
  parameter int ADDR_SYMS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [2*ADDR_SYMS-1:0]                       addrSym,
  input  logic [2*((DATA_BITS > 0) ? DATA_BITS : 1)-1:0] dataSym,
  input  tpe_pkg::strobe_t                             strobes,
  output logic                                         txOut
);
  import tpe_pkg::*;

  localparam int TOTAL = ADDR_SYMS + DATA_BITS;

  // per symbol: bit 2k = first pulse long, bit 2k+1 = second pulse long
  logic [2*TOTAL-1:0] loadVec;
  logic [2*TOTAL-1:0] shadow;
  logic               curLong;

  for (genvar g = 0; g < ADDR_SYMS; g++) begin : gAddr
    assign loadVec[2*g]   = (addrSym[2*g +: 2] != SYM_ONE);
    assign loadVec[2*g+1] = (addrSym[2*g +: 2] == SYM_ZERO);
  end

  if (DATA_BITS > 0) begin : gData
    for (genvar g = 0; g < DATA_BITS; g++) begin : gBit
      assign loadVec[2*(ADDR_SYMS+g)]   = (dataSym[2*g +: 2] == SYM_ZERO);
      assign loadVec[2*(ADDR_SYMS+g)+1] = (dataSym[2*g +: 2] == SYM_ZERO);
    end
  end else begin : gNoData
    logic unusedData;
    assign unusedData = ^dataSym;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (strobes.load) begin
      shadow <= loadVec;
    end else if (strobes.shift) begin
      shadow <= shadow >> 2;
    end
  end

  always_comb begin
    curLong = strobes.second ? shadow[1] : shadow[0];
    txOut   = strobes.active && (strobes.early || (!strobes.late && curLong));
  end
endmodule

// File: rtl/tpe_top.sv
module tpe_top #(
  parameter int ADDR_SYMS  = 10,
  parameter int DATA_BITS  = 8,
  parameter int UNIT_TICKS = 2,
  parameter int GAP_UNITS  = 32
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         en,
  input  logic [2*ADDR_SYMS-1:0]                       addrSym,
  input  logic [2*((DATA_BITS > 0) ? DATA_BITS : 1)-1:0] dataSym,
  output logic                                         txOut
);
  tpe_pkg::strobe_t strobes;

  tpe_ctrl #(
    .TOTAL_SYMS(ADDR_SYMS + DATA_BITS),
    .UNIT_TICKS(UNIT_TICKS),
    .GAP_UNITS (GAP_UNITS)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .strobes(strobes)
  );

  tpe_datapath #(
    .ADDR_SYMS(ADDR_SYMS),
    .DATA_BITS(DATA_BITS)
  ) uData (
    .clk    (clk),
    .rst    (rst),
    .addrSym(addrSym),
    .dataSym(dataSym),
    .strobes(strobes),
    .txOut  (txOut)
  );
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
  parameter int UNIT_TICKS = 2,
  parameter int GAP_UNITS  = 32
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic txOut
);
  logic [31:0] hiRun;
  logic [31:0] lowRun;
  logic        enPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun  <= '0;
      lowRun <= '0;
      enPrev <= 1'b0;
    end else begin
      enPrev <= en;
      hiRun  <= txOut ? hiRun + 1 : '0;
      lowRun <= (txOut || !en) ? '0 : lowRun + 1;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !en |=> !txOut); // R9
  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst) (en && !enPrev) |=> txOut); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!txOut && hiRun != 0 && enPrev) |-> (hiRun == UNIT_TICKS || hiRun == 3*UNIT_TICKS)); // R6
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    lowRun <= (GAP_UNITS + 3) * UNIT_TICKS); // R7
endmodule

bind tpe_top tpe_checker #(.UNIT_TICKS(UNIT_TICKS), .GAP_UNITS(GAP_UNITS)) uChk (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .txOut(txOut)
);

// File: tb/sim_tpe_top.sv
module sim_tpe_top;
  localparam int CLK_PERIOD = 10;
  localparam int ASYM  = 10;
  localparam int DBITS = 8;
  localparam int UT    = 2;
  localparam int GAPU  = 32;
  localparam int TOTAL = ASYM + DBITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2*ASYM-1:0]  addr = '0;
  logic [2*DBITS-1:0] data = '0;
  logic txOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpe_top #(.ADDR_SYMS(ASYM), .DATA_BITS(DBITS), .UNIT_TICKS(UT), .GAP_UNITS(GAPU)) u0 (
    .clk(clk), .rst(rst), .en(en), .addrSym(addr), .dataSym(data), .txOut(txOut)
  );

  function automatic logic expLong(int s, int h, logic [2*ASYM-1:0] a, logic [2*DBITS-1:0] d);
    logic [1:0] c;
    if (s < ASYM) begin
      c = a[2*s +: 2];
      if (c == 2'b00) return 1'b1;
      if (c == 2'b01) return 1'b0;
      return (h == 0);
    end
    c = d[2*(s-ASYM) +: 2];
    return (c == 2'b00);
  endfunction

  function automatic string tagOf(int s, logic [2*ASYM-1:0] a);
    if (s >= ASYM) return "R4 data";
    if (a[2*s +: 2] == 2'b00) return "R1 zero";
    if (a[2*s +: 2] == 2'b01) return "R2 one";
    return "R3 open";
  endfunction

  // samples one full word starting at the next falling edge
  task automatic checkWord(input logic [2*ASYM-1:0] a, input logic [2*DBITS-1:0] d, input string ctx);
    for (int s = 0; s < TOTAL; s++) begin
      for (int h = 0; h < 2; h++) begin
        logic [63:0] act = '0;
        logic [63:0] expv = '0;
        int idx = 0;
        logic lng = expLong(s, h, a, d);
        for (int u = 0; u < 4; u++) begin
          for (int t = 0; t < UT; t++) begin
            @(negedge clk);
            act[idx]  = txOut;
            expv[idx] = (u == 0) || (u < 3 && lng);
            idx++;
          end
        end
        checks++;
        if (act !== expv) begin
          fails++;
          $display("FAIL %s (R5/R6) %s symbol %0d pulse %0d: actual %b expected %b",
                   tagOf(s, a), ctx, s, h, act[4*UT-1:0], expv[4*UT-1:0]);
        end
      end
    end
  endtask

  task automatic checkLow(input int n, input string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txOut !== 1'b0) highs++;
    end
    checks++;
    if (highs != 0) begin
      fails++;
      $display("FAIL %s: actual %0d high cycles expected 0 over %0d", tag, highs, n);
    end
  endtask

  task automatic testReset();
    en = 1'b1;
    checkLow(6, "R9 output during reset");
    rst = 1'b0;
    checkWord(addr, data, "first word after reset");
  endtask

  task automatic testRepeat();
    checkLow(GAPU*UT, "R7 sync gap");
    checkWord(addr, data, "R7 repeated word");
    checkLow(GAPU*UT, "R7 second gap");
  endtask

  task automatic testSnapshot();
    logic [2*ASYM-1:0]  oldA;
    logic [2*DBITS-1:0] oldD;
    en = 1'b0;
    checkLow(10, "R9 idle while disabled");
    for (int k = 0; k < ASYM; k++) addr[2*k +: 2] = 2'((ASYM - 1 - k) % 4);
    for (int k = 0; k < DBITS; k++) data[2*k +: 2] = 2'((k + 1) % 4);
    oldA = addr;
    oldD = data;
    en = 1'b1;
    fork
      checkWord(oldA, oldD, "R8 word with inputs changed midway");
      begin
        repeat (40) @(negedge clk);
        for (int k = 0; k < ASYM; k++) addr[2*k +: 2] = 2'((k * 3 + 2) % 4);
        for (int k = 0; k < DBITS; k++) data[2*k +: 2] = (k % 2 == 0) ? 2'b00 : 2'b10;
      end
    join
    checkLow(GAPU*UT, "R7 gap after snapshot word");
    checkWord(addr, data, "R8 next word uses new inputs");
    checkLow(GAPU*UT, "R7 gap");
  endtask

  task automatic testMidDisable();
    repeat (30) @(negedge clk);
    en = 1'b0;
    checkLow(16, "R9 low after mid-word disable");
    en = 1'b1;
    checkWord(addr, data, "R9 restart from symbol 0");
    checkLow(GAPU*UT, "R7 gap after restart");
  endtask

  initial begin
    for (int k = 0; k < ASYM; k++) addr[2*k +: 2] = 2'(k % 4);
    for (int k = 0; k < DBITS; k++) data[2*k +: 2] = 2'((k * 3) % 4);
    @(negedge clk);
    testReset();
    testRepeat();
    testSnapshot();
    testMidDisable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule